// File: doc/BRIEF.md
# Clamped PI Offset Compensator

This block is a fixed-point proportional-integral regulator that cancels a slowly varying DC offset in a current-controlled power stage. Once per control period a signed offset-error sample arrives with a one-cycle strobe. The block then produces a signed correction term that a later stage adds to the current reference. The correction is the sum of a proportional part and an integral part, each scaled by a programmable gain, and a fixed fractional width sets the binary point.

The correction is bounded by an upper limit and a separate lower limit, both taken from input ports. Anti-windup works by freezing rather than by back-calculation. When the last result was pinned at the upper limit, the integrator keeps its value for as long as new errors are zero or positive. It starts accumulating again on the first negative error. The lower limit follows the mirror rule. Between the limits the clamp logic leaves the result untouched. The result is registered and comes with a one-cycle valid pulse at a fixed latency.

Top module: `pi_offset_comp`

## Requirements
- R1: Reset drives `comp_out` to 0 and `comp_vld` low, sets the integrator to zero and marks the clamp state as free. The first result after reset therefore uses only the new sample's integral increment.
- R2: For each cycle with `smp_vld` high, `comp_vld` is high for exactly one cycle, two clock edges later. `comp_vld` is never high otherwise, and strobes may arrive on consecutive cycles.
- R3: With gains kp and ki, error e and FRAC_W fractional bits, each sample first updates the integrator I to I + ki*e, unless the sample is frozen. The unclamped result is floor((kp*e + I) / 2^FRAC_W) in two's complement. When that value lies strictly between the limits it is output unchanged.
- R4: If the unclamped result is greater than or equal to `cfg_hi`, the output equals `cfg_hi` and the clamp state becomes "at upper limit".
- R5: If the unclamped result is below `cfg_hi` and less than or equal to `cfg_lo`, the output equals `cfg_lo` and the clamp state becomes "at lower limit".
- R6: While the clamp state is "at upper limit", a sample with error greater than or equal to zero leaves the integrator unchanged.
- R7: While the clamp state is "at upper limit", a sample with negative error adds ki*e to the integrator in that same sample.
- R8: While the clamp state is "at lower limit", a sample with error less than or equal to zero leaves the integrator unchanged, and a sample with positive error adds ki*e to it.
- R9: If `cfg_lo` is greater than `cfg_hi`, the upper limit wins and every output equals `cfg_hi`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_kp | input | GAIN_W | Signed proportional gain, FRAC_W fractional bits |
| cfg_ki | input | GAIN_W | Signed integral gain per sample, FRAC_W fractional bits |
| cfg_hi | input | DATA_W | Signed upper output limit |
| cfg_lo | input | DATA_W | Signed lower output limit |
| smp_vld | input | 1 | One-cycle strobe marking a new error sample |
| smp_err | input | DATA_W | Signed offset-error sample |
| comp_vld | output | 1 | One-cycle pulse marking a new correction |
| comp_out | output | DATA_W | Signed, registered, clamped correction term |

## Verification
The bench drives the error up into the upper limit, keeps it positive and then flips it negative. This exposes a design that winds up while pinned, which would stay pinned long after the error reverses, and also a design that never resumes, which would stay stuck. The same pattern runs mirrored at the lower limit. Further patterns use an error of exactly zero at each limit, which catches a hold test that uses the wrong inequality, and inverted limits, where giving the lower limit priority would return the wrong value. Strobes arrive back-to-back, with gaps, and around a mid-run reset. A reset that left the integrator untouched shows up as a wrong first result after reset, and a wrong latency as a misplaced valid pulse.

// File: rtl/pi_clamp_pkg.sv
package pi_clamp_pkg;
   typedef enum logic [1:0] {
      CLP_FREE = 2'd0,
      CLP_HIGH = 2'd1,
      CLP_LOW  = 2'd2
   } clp_state_e;
endpackage

// File: rtl/pi_prod.sv
// Stage 1: registers the proportional product, the integral increment and the error sign.
module pi_prod #(
   parameter int DATA_W = 16,
   parameter int GAIN_W = 16,
   localparam int PROD_W = DATA_W + GAIN_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_vld,
   input  logic signed [DATA_W-1:0] in_err,
   input  logic signed [GAIN_W-1:0] kp,
   input  logic signed [GAIN_W-1:0] ki,
   output logic                     out_vld,
   output logic signed [PROD_W-1:0] out_prop,
   output logic signed [PROD_W-1:0] out_incr,
   output logic                     out_neg,
   output logic                     out_pos
);
   logic signed [PROD_W-1:0] err_x, kp_x, ki_x;

   assign err_x = {{GAIN_W{in_err[DATA_W-1]}}, in_err};
   assign kp_x  = {{DATA_W{kp[GAIN_W-1]}}, kp};
   assign ki_x  = {{DATA_W{ki[GAIN_W-1]}}, ki};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         out_prop <= '0;
         out_incr <= '0;
         out_neg  <= 1'b0;
         out_pos  <= 1'b0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) begin
            out_prop <= kp_x * err_x;
            out_incr <= ki_x * err_x;
            out_neg  <= in_err[DATA_W-1];
            out_pos  <= !in_err[DATA_W-1] && (in_err != '0);
         end
      end
   end
endmodule

// File: rtl/pi_integ.sv
// Integrator with freeze-at-limit anti-windup.
module pi_integ
   import pi_clamp_pkg::*;
#(
   parameter int PROD_W = 32,
   parameter int ACC_W  = 40
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    upd,
   input  logic signed [PROD_W-1:0] incr,
   input  logic                    err_neg,
   input  logic                    err_pos,
   input  clp_state_e              clamp_st,
   output logic signed [ACC_W-1:0] integ_nxt
);
   logic signed [ACC_W-1:0] integ_q;
   logic signed [ACC_W-1:0] incr_x;
   logic                    freeze;

   assign incr_x = {{(ACC_W-PROD_W){incr[PROD_W-1]}}, incr};
   assign freeze = ((clamp_st == CLP_HIGH) && !err_neg) ||
                   ((clamp_st == CLP_LOW)  && !err_pos);
   assign integ_nxt = freeze ? integ_q : integ_q + incr_x;

   always_ff @(posedge clk) begin
      if (!rst_n)   integ_q <= '0;
      else if (upd) integ_q <= integ_nxt;
   end

   a_r6_hold_at_high: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && clamp_st == CLP_HIGH && !err_neg) |=> $stable(integ_q));
   a_r7_resume_from_high: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && clamp_st == CLP_HIGH && err_neg && incr != '0) |=> !$stable(integ_q));
   a_r8_hold_at_low: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && clamp_st == CLP_LOW && !err_pos) |=> $stable(integ_q));
   a_r8_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> $stable(integ_q));
endmodule

// File: rtl/pi_limit.sv
// Stage 2: sums both terms, rescales, clamps and registers the result and the clamp state.
module pi_limit
   import pi_clamp_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int PROD_W  = 32,
   parameter int ACC_W   = 40,
   parameter int FRAC_W  = 8,
   parameter bit ROUND_N = 1'b0,
   localparam int SUM_W  = ACC_W + 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     upd,
   input  logic signed [PROD_W-1:0] prop,
   input  logic signed [ACC_W-1:0]  integ_nxt,
   input  logic signed [DATA_W-1:0] hi,
   input  logic signed [DATA_W-1:0] lo,
   output logic                     out_vld,
   output logic signed [DATA_W-1:0] out_val,
   output clp_state_e               clamp_st
);
   logic signed [SUM_W-1:0]  sum, scaled, hi_x, lo_x;
   logic signed [DATA_W-1:0] lo_eff, res_d;
   clp_state_e               st_d;

   assign sum = {{(SUM_W-PROD_W){prop[PROD_W-1]}}, prop} +
                {integ_nxt[ACC_W-1], integ_nxt};

   generate
      if (FRAC_W == 0) begin : g_noscale
         assign scaled = sum;
      end else if (ROUND_N) begin : g_round
         localparam logic signed [SUM_W-1:0] HALF = SUM_W'(1) <<< (FRAC_W - 1);
         assign scaled = (sum + HALF) >>> FRAC_W;
      end else begin : g_floor
         assign scaled = sum >>> FRAC_W;
      end
   endgenerate

   assign lo_eff = (lo > hi) ? hi : lo;
   assign hi_x   = {{(SUM_W-DATA_W){hi[DATA_W-1]}}, hi};
   assign lo_x   = {{(SUM_W-DATA_W){lo_eff[DATA_W-1]}}, lo_eff};

   always_comb begin
      if (scaled >= hi_x) begin
         res_d = hi;
         st_d  = CLP_HIGH;
      end else if (scaled <= lo_x) begin
         res_d = lo_eff;
         st_d  = CLP_LOW;
      end else begin
         res_d = scaled[DATA_W-1:0];
         st_d  = CLP_FREE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         out_val  <= '0;
         clamp_st <= CLP_FREE;
      end else begin
         out_vld <= upd;
         if (upd) begin
            out_val  <= res_d;
            clamp_st <= st_d;
         end
      end
   end

   a_r4_never_above_high: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> out_val <= $past(hi));
   a_r5_never_below_low: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && lo <= hi) |=> out_val >= $past(lo));
   a_r9_high_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && lo > hi) |=> out_val == $past(hi));
   a_r4_state_matches_out: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && lo <= hi) |=> ((clamp_st == CLP_FREE) == (out_val != $past(hi) && out_val != $past(lo))));
endmodule

// File: rtl/pi_offset_comp.sv
module pi_offset_comp
   import pi_clamp_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int GAIN_W  = 16,
   parameter int FRAC_W  = 8,
   parameter int GUARD_W = 8,
   parameter bit ROUND_N = 1'b0,
   localparam int PROD_W = DATA_W + GAIN_W,
   localparam int ACC_W  = PROD_W + GUARD_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic signed [GAIN_W-1:0] cfg_kp,
   input  logic signed [GAIN_W-1:0] cfg_ki,
   input  logic signed [DATA_W-1:0] cfg_hi,
   input  logic signed [DATA_W-1:0] cfg_lo,
   input  logic                     smp_vld,
   input  logic signed [DATA_W-1:0] smp_err,
   output logic                     comp_vld,
   output logic signed [DATA_W-1:0] comp_out
);
   generate
      if (DATA_W < 2)      begin : g_bad_data  $error("DATA_W must be at least 2");   end
      if (GAIN_W < 2)      begin : g_bad_gain  $error("GAIN_W must be at least 2");   end
      if (FRAC_W < 0 || FRAC_W >= GAIN_W)
                           begin : g_bad_frac  $error("FRAC_W must lie in [0, GAIN_W)"); end
      if (GUARD_W < 2)     begin : g_bad_guard $error("GUARD_W must be at least 2");  end
   endgenerate

   logic                     s1_vld, s1_neg, s1_pos;
   logic signed [PROD_W-1:0] s1_prop, s1_incr;
   logic signed [ACC_W-1:0]  integ_nxt;
   clp_state_e               clamp_st;

   pi_prod #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_prod (
      .clk(clk), .rst_n(rst_n), .in_vld(smp_vld), .in_err(smp_err),
      .kp(cfg_kp), .ki(cfg_ki), .out_vld(s1_vld), .out_prop(s1_prop),
      .out_incr(s1_incr), .out_neg(s1_neg), .out_pos(s1_pos));

   pi_integ #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_integ (
      .clk(clk), .rst_n(rst_n), .upd(s1_vld), .incr(s1_incr),
      .err_neg(s1_neg), .err_pos(s1_pos), .clamp_st(clamp_st),
      .integ_nxt(integ_nxt));

   pi_limit #(.DATA_W(DATA_W), .PROD_W(PROD_W), .ACC_W(ACC_W),
              .FRAC_W(FRAC_W), .ROUND_N(ROUND_N)) u_limit (
      .clk(clk), .rst_n(rst_n), .upd(s1_vld), .prop(s1_prop),
      .integ_nxt(integ_nxt), .hi(cfg_hi), .lo(cfg_lo),
      .out_vld(comp_vld), .out_val(comp_out), .clamp_st(clamp_st));

   a_r2_latency_two: assert property (@(posedge clk) disable iff (!rst_n)
      smp_vld |-> ##2 comp_vld);
   a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
      comp_vld |-> $past(smp_vld, 2));
   a_r1_idle_after_reset: assert property (@(posedge clk)
      !rst_n |=> (!comp_vld && comp_out == '0));
endmodule

// File: tb/test_pi_offset_comp.sv
`timescale 1ns/1ps
module test_pi_offset_comp;
   localparam int DW = 16;
   localparam int GW = 16;
   localparam int FW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic signed [GW-1:0] cfg_kp = '0, cfg_ki = '0;
   logic signed [DW-1:0] cfg_hi = '0, cfg_lo = '0;
   logic smp_vld = 1'b0;
   logic signed [DW-1:0] smp_err = '0;
   logic comp_vld;
   logic signed [DW-1:0] comp_out;

   always #5 clk = ~clk;

   pi_offset_comp #(.DATA_W(DW), .GAIN_W(GW), .FRAC_W(FW)) i_pi_offset_comp (
      .clk(clk), .rst_n(rst_n), .cfg_kp(cfg_kp), .cfg_ki(cfg_ki),
      .cfg_hi(cfg_hi), .cfg_lo(cfg_lo), .smp_vld(smp_vld), .smp_err(smp_err),
      .comp_vld(comp_vld), .comp_out(comp_out));

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // behavioural model: 0 free, 1 at upper, 2 at lower
   longint m_int = 0;
   int     m_st = 0;
   bit     p_v = 1'b0;
   longint p_out = 0;
   string  p_tag = "R3";
   bit     after_rst = 1'b0;
   int     seed = 32'h1234_5678;

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_sample(input longint e);
      longint kp, ki, hi, lo, s, o;
      bit hold;
      string tag;
      kp = longint'(cfg_kp); ki = longint'(cfg_ki);
      hi = longint'(cfg_hi); lo = longint'(cfg_lo);
      tag = "R3";
      hold = (m_st == 1 && e >= 0) || (m_st == 2 && e <= 0);
      if (!hold) m_int = m_int + ki * e;
      if (m_st == 1) tag = hold ? "R6" : "R7";
      if (m_st == 2) tag = "R8";
      s = kp * e + m_int;
      s = s >>> FW;
      if (lo > hi) lo = hi;
      if (s >= hi)      begin o = hi; m_st = 1; if (tag == "R3") tag = "R4"; end
      else if (s <= lo) begin o = lo; m_st = 2; if (tag == "R3") tag = "R5"; end
      else              begin o = s;  m_st = 0; end
      if (longint'(cfg_lo) > longint'(cfg_hi)) tag = "R9";
      if (after_rst) begin tag = "R1"; after_rst = 1'b0; end
      p_out = o; p_tag = tag;
   endtask

   // one clock: drive, edge, advance model, compare after the edge
   task automatic cyc(input bit v, input int e);
      bit     ev;
      longint eo;
      string  et;
      smp_vld = v;
      smp_err = DW'(e);
      @(posedge clk);
      ev = p_v; eo = p_out; et = p_tag;
      p_v = v;
      if (v) model_sample(longint'(e));
      #1;
      check(comp_vld == ev, "R2", longint'(comp_vld), longint'(ev));
      if (ev) check(longint'(comp_out) == eo, et, longint'(comp_out), eo);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) cyc(1'b0, 0);
   endtask

   task automatic do_reset();
      smp_vld = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      rst_n = 1'b1;
      m_int = 0; m_st = 0; p_v = 1'b0; after_rst = 1'b1;
      check(comp_vld == 1'b0, "R1", longint'(comp_vld), 0);
      check(comp_out == '0, "R1", longint'(comp_out), 0);
   endtask

   function automatic int rnd(input int span);
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >>> 17);
      seed = seed ^ (seed << 5);
      return (((seed % (2 * span + 1)) + (2 * span + 1)) % (2 * span + 1)) - span;
   endfunction

   initial begin
      cfg_kp = 16'sd256;  // 1.0
      cfg_ki = 16'sd64;   // 0.25
      cfg_hi = 16'sd200;
      cfg_lo = -16'sd150;
      #2;
      do_reset();
      // R1: first result after reset uses only the new increment
      cyc(1'b1, 12); idle(2);
      // R3: small mixed errors, spaced and back-to-back
      for (int k = 0; k < 10; k++) begin cyc(1'b1, rnd(20)); idle(k % 3); end
      for (int k = 0; k < 8; k++) cyc(1'b1, rnd(15));
      idle(2);
      // R4/R6/R7: drive into the upper limit, hold with positive and zero error, release
      for (int k = 0; k < 8; k++) cyc(1'b1, 100);
      cyc(1'b1, 0);
      cyc(1'b1, 100);
      cyc(1'b1, -5);
      cyc(1'b1, -5);
      idle(2);
      // R5/R8: drive into the lower limit, hold, release
      for (int k = 0; k < 12; k++) cyc(1'b1, -120);
      cyc(1'b1, 0);
      cyc(1'b1, -60);
      cyc(1'b1, 7);
      cyc(1'b1, 7);
      idle(3);
      // R9: lower limit set above the upper
      cfg_lo = 16'sd50; cfg_hi = 16'sd20;
      idle(2);
      for (int k = 0; k < 6; k++) cyc(1'b1, rnd(60));
      idle(2);
      cfg_lo = -16'sd30; cfg_hi = 16'sd40;
      idle(2);
      // mixed pattern with tighter limits and gaps
      for (int k = 0; k < 40; k++) begin cyc(1'b1, rnd(50)); if (k % 5 == 0) idle(1); end
      idle(2);
      // R1: mid-run reset clears the integrator
      for (int k = 0; k < 4; k++) cyc(1'b1, 35);
      do_reset();
      cyc(1'b1, 3);
      cyc(1'b1, 3);
      idle(3);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL R2 watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule